// File: doc/BRIEF.md
# Always-On Match Timer with Two-Stage Clock Divider

This block is a free-running timer that lives in an always-on power domain. It counts events taken from one of three clock sources: two oscillators and the peripheral clock. Each source reaches the block as a one-cycle clock-enable pulse on the block's own clock. The chosen source first passes through a prescaler that can be switched off. A second, programmable tick divider follows the prescaler. Every tick produced by that chain advances the count register by one.

Software loads an end value and starts the timer. When a tick brings the count equal to the end value, the block sets a sticky match flag. The flag can be read at two addresses: the status register and a shadow register. In the same cycle the block raises a one-cycle match event for the interrupt controller, which takes it on group 0, bit 0. On the next tick the count wraps to zero and counting goes on. The flag stays set until software writes a reset command, which also zeroes the count.

Stopping the timer freezes the count and discards any partial divider phase. A restart therefore always begins with a full prescale period.

Top module: `aot_timer`

## Requirements
- R1: After reset every register reads as zero, the timer is stopped and `matchEvt` is low.
- R2: The source is chosen by the control register at offset 0x00. When bit 25 is 1, `pclkEn` is used. When bit 25 is 0, bit 0 picks `osc1En` (1) or `osc0En` (0). Pulses on the inputs that are not chosen have no effect on the count.
- R3: Bit 24 of the control register enables the prescaler. When it is enabled, the prescaler emits one pulse per (N+1) source pulses, where N is the value of bits 23:20. When it is disabled, every source pulse passes through, whatever bits 23:20 hold.
- R4: The tick divider at offset 0x74 emits one count tick per D prescaler pulses. A value of 0 behaves as 1.
- R5: Bit 0 of the command register at offset 0x6C runs the timer (1) or stops it (0). A stopped timer holds its count. Stopping also clears the prescaler and tick-divider phases, so a restart needs a full prescale period before the first tick.
- R6: The end value is held at offset 0x70. A tick that makes the count equal to the end value sets status bit 0 (offset 0x7C) and shadow bit 0 (offset 0x04). In the same clock it drives `matchEvt` high for one cycle.
- R7: On the tick after the count equals the end value, the count returns to zero and counting continues. The match flags stay set across further ticks.
- R8: Writing 1 to command bit 1 zeroes the count, clears both match flags and clears the divider phases. Command bit 1 always reads as 0, and bit 0 reads back the run state.
- R9: A write takes effect at the clock edge it is presented on. `rdData` shows the register at `addr` one cycle after the address is presented. The count (0x78), status (0x7C) and shadow (0x04) registers are read-only: writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| osc0En | input | 1 | Clock-enable pulse standing for oscillator 0 |
| osc1En | input | 1 | Clock-enable pulse standing for oscillator 1 |
| pclkEn | input | 1 | Clock-enable pulse standing for the peripheral clock |
| addr | input | 8 | Register byte address |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| matchEvt | output | 1 | One-cycle match event to the interrupt controller |

## Verification
Each fault inside the block shows up at the ports in a different way. A wrong source or divider phase shows up as a wrong count, read back after a known number of source pulses. A stale prescaler phase after a stop shows up on the first pulse after the restart. A match decision that is wrong, or late by a tick, shows up as a missing or extra `matchEvt` pulse, visible one clock after the offending tick. It also shows up as a status bit that differs from the count reached. A flag that is not sticky, or a reset command that does not clear everything, is seen in the first status read after the event.

// File: rtl/aot_pkg.sv
package aot_pkg;
  localparam int DATA_W = 32;
  localparam int PDIV_W = 4;

  localparam logic [7:0] OFF_CTRL   = 8'h00;
  localparam logic [7:0] OFF_SHADOW = 8'h04;
  localparam logic [7:0] OFF_CMD    = 8'h6C;
  localparam logic [7:0] OFF_END    = 8'h70;
  localparam logic [7:0] OFF_TDIV   = 8'h74;
  localparam logic [7:0] OFF_COUNT  = 8'h78;
  localparam logic [7:0] OFF_STATUS = 8'h7C;

  localparam int BIT_OSC   = 0;
  localparam int BIT_SRC   = 25;
  localparam int BIT_DIVEN = 24;
  localparam int DIV_LSB   = 20;

  typedef struct packed {
    logic run;
    logic clear;
    logic tick;
  } aotStrobe_t;
endpackage

// File: rtl/aot_datapath.sv
module aot_datapath
  import aot_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  aotStrobe_t       strb,
  input  logic [CNT_W-1:0] endVal,
  output logic [CNT_W-1:0] countVal,
  output logic             matchFlag,
  output logic             matchEvt
);
  logic [CNT_W-1:0] nextCount;

  // wrap to zero on the tick after the end value is reached
  always_comb begin
    if (countVal == endVal) nextCount = '0;
    else                    nextCount = countVal + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countVal  <= '0;
      matchFlag <= 1'b0;
      matchEvt  <= 1'b0;
    end else begin
      matchEvt <= 1'b0;
      if (strb.clear) begin
        countVal  <= '0;
        matchFlag <= 1'b0;
      end else if (strb.tick) begin
        countVal <= nextCount;
        if (nextCount == endVal) begin
          matchFlag <= 1'b1;
          matchEvt  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/aot_ctrl.sv
module aot_ctrl
  import aot_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              osc0En,
  input  logic              osc1En,
  input  logic              pclkEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [CNT_W-1:0]  countVal,
  input  logic              matchFlag,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  endVal,
  output aotStrobe_t        strb
);
  logic              oscSel, srcSel, divEn, runReg;
  logic [PDIV_W-1:0] divSel, preCnt;
  logic [CNT_W-1:0]  tdivReg, tdCnt, tdLimit;
  logic              srcPulse, preTick, tdDone, clearCmd, phaseClr;
  logic [DATA_W-1:0] rdNext, countExt, endExt, tdivExt;

  assign clearCmd = wrEn && (addr == ADDR_W'(OFF_CMD)) && wrData[1];
  assign phaseClr = !runReg || clearCmd;

  // register writes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oscSel  <= 1'b0;
      srcSel  <= 1'b0;
      divEn   <= 1'b0;
      divSel  <= '0;
      runReg  <= 1'b0;
      endVal  <= '0;
      tdivReg <= '0;
    end else if (wrEn) begin
      case (addr)
        ADDR_W'(OFF_CTRL): begin
          oscSel <= wrData[BIT_OSC];
          srcSel <= wrData[BIT_SRC];
          divEn  <= wrData[BIT_DIVEN];
          divSel <= wrData[DIV_LSB +: PDIV_W];
        end
        ADDR_W'(OFF_CMD):  runReg  <= wrData[0];
        ADDR_W'(OFF_END):  endVal  <= wrData[CNT_W-1:0];
        ADDR_W'(OFF_TDIV): tdivReg <= wrData[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  // source selection: peripheral clock overrides the oscillator choice
  assign srcPulse = srcSel ? pclkEn : (oscSel ? osc1En : osc0En);

  // first stage: optional divide-by-(divSel+1)
  assign preTick = runReg && srcPulse && (!divEn || (preCnt >= divSel));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                preCnt <= '0;
    else if (phaseClr)        preCnt <= '0;
    else if (srcPulse && divEn)
      preCnt <= (preCnt >= divSel) ? '0 : preCnt + 1'b1;
  end

  // second stage: tick divider, 0 treated as 1
  assign tdLimit = (tdivReg == '0) ? '0 : tdivReg - 1'b1;
  assign tdDone  = (tdCnt >= tdLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         tdCnt <= '0;
    else if (phaseClr) tdCnt <= '0;
    else if (preTick)  tdCnt <= tdDone ? '0 : tdCnt + 1'b1;
  end

  assign strb.run   = runReg;
  assign strb.clear = clearCmd;
  assign strb.tick  = preTick && tdDone;

  // read path
  always_comb begin
    countExt = '0;
    countExt[CNT_W-1:0] = countVal;
    endExt = '0;
    endExt[CNT_W-1:0] = endVal;
    tdivExt = '0;
    tdivExt[CNT_W-1:0] = tdivReg;
    rdNext = '0;
    case (addr)
      ADDR_W'(OFF_CTRL): begin
        rdNext[BIT_OSC]             = oscSel;
        rdNext[BIT_SRC]             = srcSel;
        rdNext[BIT_DIVEN]           = divEn;
        rdNext[DIV_LSB +: PDIV_W]   = divSel;
      end
      ADDR_W'(OFF_SHADOW): rdNext[0] = matchFlag;
      ADDR_W'(OFF_CMD):    rdNext[0] = runReg;
      ADDR_W'(OFF_END):    rdNext    = endExt;
      ADDR_W'(OFF_TDIV):   rdNext    = tdivExt;
      ADDR_W'(OFF_COUNT):  rdNext    = countExt;
      ADDR_W'(OFF_STATUS): rdNext[0] = matchFlag;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdNext;
  end
endmodule

// File: rtl/aot_timer.sv
module aot_timer
  import aot_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              osc0En,
  input  logic              osc1En,
  input  logic              pclkEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              matchEvt
);
  aotStrobe_t       strb;
  logic [CNT_W-1:0] endVal, countVal;
  logic             matchFlag;

  aot_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .osc0En(osc0En), .osc1En(osc1En), .pclkEn(pclkEn),
    .addr(addr), .wrEn(wrEn), .wrData(wrData), .countVal(countVal),
    .matchFlag(matchFlag), .rdData(rdData), .endVal(endVal), .strb(strb)
  );

  aot_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .endVal(endVal),
    .countVal(countVal), .matchFlag(matchFlag), .matchEvt(matchEvt)
  );
endmodule

// File: rtl/aot_timer_chk.sv
module aot_timer_chk
  import aot_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input aotStrobe_t       strb,
  input logic [CNT_W-1:0] countVal,
  input logic [CNT_W-1:0] endVal,
  input logic             matchFlag,
  input logic             matchEvt
);
  // R6
  match_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    matchEvt |-> matchFlag);

  // R6
  match_at_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    matchEvt |-> (countVal == endVal));

  // R5
  stop_holds_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.run && !strb.clear) |=> $stable(countVal));

  // R7
  wrap_after_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && !strb.clear && countVal == endVal) |=> (countVal == '0));

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (matchFlag && !strb.clear) |=> matchFlag);

  // R8
  clear_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (countVal == '0 && !matchFlag && !matchEvt));
endmodule

bind aot_timer aot_timer_chk #(.CNT_W(CNT_W)) chk (
  .clk(clk), .rstN(rstN), .strb(strb), .countVal(countVal),
  .endVal(endVal), .matchFlag(matchFlag), .matchEvt(matchEvt)
);

// File: tb/aot_timer_test.sv
module aot_timer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        osc0En = 1'b0, osc1En = 1'b0, pclkEn = 1'b0;
  logic [7:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        matchEvt;

  int nChk = 0, nFail = 0, evtCnt = 0;
  bit timedOut = 0;

  always #5 clk = ~clk;

  aot_timer uut (
    .clk(clk), .rstN(rstN), .osc0En(osc0En), .osc1En(osc1En), .pclkEn(pclkEn),
    .addr(addr), .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .matchEvt(matchEvt)
  );

  always @(negedge clk) if (matchEvt) evtCnt++;

  // entry: sel[30:29] divEn[28] div[27:24] tdiv[23:16] pulses[15:8] expCount[7:0]
  localparam logic [30:0] VEC [6] = '{
    {2'd0, 1'b0, 4'd0, 8'd0, 8'd10, 8'd10},
    {2'd1, 1'b0, 4'd0, 8'd1, 8'd7,  8'd7 },
    {2'd2, 1'b1, 4'd3, 8'd0, 8'd20, 8'd5 },
    {2'd0, 1'b1, 4'd1, 8'd3, 8'd25, 8'd4 },
    {2'd2, 1'b0, 4'd5, 8'd2, 8'd9,  8'd4 },
    {2'd1, 1'b1, 4'd0, 8'd4, 8'd17, 8'd4 }
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rdData;
  endtask

  // each pulse: all inputs high, then only the unselected ones high
  task automatic pulse(input int sel, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      osc0En = 1'b1; osc1En = 1'b1; pclkEn = 1'b1;
      @(negedge clk);
      osc0En = (sel != 0); osc1En = (sel != 1); pclkEn = (sel != 2);
    end
    @(negedge clk);
    osc0En = 1'b0; osc1En = 1'b0; pclkEn = 1'b0;
  endtask

  task automatic runTests;
    logic [31:0] v;
    logic [31:0] ctl;
    // R1 reset state
    rd(8'h00, v); check("R1 ctrl", v, 0);
    rd(8'h04, v); check("R1 shadow", v, 0);
    rd(8'h6C, v); check("R1 cmd", v, 0);
    rd(8'h70, v); check("R1 end", v, 0);
    rd(8'h74, v); check("R1 tdiv", v, 0);
    rd(8'h78, v); check("R1 count", v, 0);
    rd(8'h7C, v); check("R1 status", v, 0);
    check("R1 matchEvt", {31'b0, matchEvt}, 0);

    // R2 R3 R4 vector table
    foreach (VEC[k]) begin
      ctl = 32'h0;
      if (VEC[k][30:29] == 2'd1) ctl[0] = 1'b1;
      if (VEC[k][30:29] == 2'd2) begin ctl[25] = 1'b1; ctl[0] = 1'b1; end
      ctl[24] = VEC[k][28];
      ctl[23:20] = VEC[k][27:24];
      wr(8'h6C, 32'h2);
      wr(8'h00, ctl);
      wr(8'h74, {24'b0, VEC[k][23:16]});
      wr(8'h70, 32'hFFFF_FFFF);
      wr(8'h6C, 32'h1);
      pulse(int'(VEC[k][30:29]), int'(VEC[k][15:8]));
      wr(8'h6C, 32'h0);
      rd(8'h78, v);
      check($sformatf("R2 R3 R4 vector %0d count", k), v, {24'b0, VEC[k][7:0]});
    end

    // R9 register readback and write timing
    wr(8'h00, 32'h0130_0000);
    rd(8'h00, v); check("R9 ctrl readback", v, 32'h0130_0000);
    wr(8'h00, 32'h0000_0000);
    wr(8'h74, 32'h0);
    wr(8'h70, 32'd3);
    rd(8'h70, v); check("R9 end readback", v, 3);

    // R6 match
    wr(8'h6C, 32'h2);
    evtCnt = 0;
    wr(8'h6C, 32'h1);
    rd(8'h6C, v); check("R8 cmd reads run only", v, 1);
    pulse(0, 2);
    check("R6 no event before end", evtCnt, 0);
    pulse(0, 1);
    rd(8'h78, v); check("R6 count at end", v, 3);
    rd(8'h7C, v); check("R6 status set", v, 1);
    rd(8'h04, v); check("R6 shadow set", v, 1);
    check("R6 one event", evtCnt, 1);
    // R7 wrap and sticky
    pulse(0, 1);
    rd(8'h78, v); check("R7 wrap to zero", v, 0);
    rd(8'h7C, v); check("R7 flag sticky", v, 1);
    pulse(0, 3);
    rd(8'h78, v); check("R7 second match count", v, 3);
    check("R7 second event", evtCnt, 2);

    // R5 stop holds count
    wr(8'h6C, 32'h0);
    pulse(0, 5);
    rd(8'h78, v); check("R5 stopped holds count", v, 3);

    // R9 read-only registers
    wr(8'h78, 32'd9);
    rd(8'h78, v); check("R9 count read-only", v, 3);

    // R8 reset command
    wr(8'h6C, 32'h2);
    rd(8'h78, v); check("R8 count zero", v, 0);
    rd(8'h7C, v); check("R8 status clear", v, 0);
    rd(8'h04, v); check("R8 shadow clear", v, 0);
    wr(8'h7C, 32'h1);
    rd(8'h7C, v); check("R9 status read-only", v, 0);

    // R5 prescaler phase cleared by stop
    wr(8'h70, 32'hFFFF_FFFF);
    wr(8'h00, 32'h0130_0000);
    wr(8'h6C, 32'h1);
    pulse(0, 3);
    wr(8'h6C, 32'h0);
    wr(8'h6C, 32'h1);
    pulse(0, 1);
    rd(8'h78, v); check("R5 phase cleared on stop", v, 0);
    pulse(0, 3);
    rd(8'h78, v); check("R5 full period after restart", v, 1);

    // R3 divider disabled ignores field
    wr(8'h6C, 32'h2);
    wr(8'h00, 32'h00F0_0000);
    wr(8'h6C, 32'h1);
    pulse(0, 2);
    rd(8'h78, v); check("R3 divider off passes through", v, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    fork
      runTests();
      begin
        repeat (100000) @(posedge clk);
        timedOut = 1;
      end
    join_any
    if (timedOut) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule